// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 30-bit logical address into a 32-bit physical address by walking a two-level page table held in memory. A walk is launched with a one-cycle start pulse carrying the logical address; the block samples the page-table base at that moment. It then issues two dependent reads on a single request/response memory port. The first read fetches an entry from the outer table, which gives the location of an inner table. The second read fetches an entry from that inner table, which gives the frame number.

The logical address splits into an 8-bit outer index in bits 29:22, a 10-bit inner index in bits 21:12 and a 12-bit byte offset in bits 11:0. With 4-byte entries, each table fits in one 4 KB page. Every table entry is 32 bits wide, with a present flag at bit 0 and a 20-bit frame number in bits 31:12. If an entry has its present flag clear, the walk stops at that level and reports a fault. The level that faulted is also reported. Completion is marked by a one-cycle done pulse. The result outputs then hold their values until the next walk finishes.

Top module: `pt_walk2`

## Requirements
- R1: After reset, done_o, mem_req_o, fault_o, fault_lvl_o and paddr_o are all 0.
- R2: A start pulse seen while idle samples vaddr_i and ptbase_i. The first read address is ptbase + 4 * vaddr[29:22].
- R3: When the outer entry has bit 0 set, the second read address is {outer_entry[31:12], 12'h000} + 4 * vaddr[21:12].
- R4: When the inner entry has bit 0 set, the walk ends with fault_o = 0 and paddr_o = {inner_entry[31:12], vaddr[11:0]}.
- R5: When the outer entry has bit 0 clear, the walk ends after exactly one read with fault_o = 1, fault_lvl_o = 0 (outer level) and paddr_o = 0.
- R6: When the inner entry has bit 0 clear, the walk ends with fault_o = 1, fault_lvl_o = 1 (inner level) and paddr_o = 0.
- R7: mem_req_o stays high with an unchanged mem_addr_o on every cycle that a read waits for mem_rsp_valid_i. Any response latency is accepted.
- R8: done_o is a single-cycle pulse. It rises 3 + 2L clock edges after the start edge for a full walk, and 2 + L edges for an outer fault, where L is the number of waiting cycles per read.
- R9: While a walk is in progress, start_i, vaddr_i and ptbase_i are ignored. No second walk follows.
- R10: paddr_o, fault_o and fault_lvl_o change only at the edge where done_o rises. They stay unchanged while done_o is low.
- R11: mem_rsp_valid_i asserted while no read is outstanding has no effect: no done pulse, no request and no change of the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a walk (honoured only when idle) |
| vaddr_i | input | 30 | Logical address to translate |
| ptbase_i | input | 32 | Byte address of the outer table |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| fault_o | output | 1 | Last walk hit an absent entry |
| fault_lvl_o | output | 1 | Faulting level: 0 outer, 1 inner |
| paddr_o | output | 32 | Translated physical address (0 on a fault) |

## Verification
The embedded properties check several rules on every cycle:
- a waiting request keeps its address;
- done lasts a single cycle and the walk then returns to idle;
- a walk in its second half never restarts;
- results stay frozen outside the done pulse;
- a faulted result always carries a zero address.

Some behaviours depend on memory contents and arithmetic, so only the directed scenarios can show them:
- the read addresses formed from the base and the indices;
- the frame and offset concatenation;
- which level reports a fault;
- the cycle count for each response latency;
- the rejection of a start pulse or a stray response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_e;

  localparam logic LVL_OUTER = 1'b0;
  localparam logic LVL_INNER = 1'b1;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ENTRY_W = 32,
  parameter int FRAME_W = 20
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               present_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int SPARE_HI = ENTRY_W - FRAME_W - 1;

  logic unused_spare;

  assign present_o    = entry_i[0];
  assign frame_o      = entry_i[ENTRY_W-1 -: FRAME_W];
  assign unused_spare = ^entry_i[SPARE_HI:1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int L1_W        = 8,
  parameter int L2_W        = 10,
  parameter int ENTRY_BYTES = 4,
  localparam int FRAME_W    = PA_W - OFF_W
) (
  input  logic               sel_inner_i,
  input  logic [PA_W-1:0]    tbl_base_i,
  input  logic [FRAME_W-1:0] inner_frame_i,
  input  logic [L1_W-1:0]    l1_idx_i,
  input  logic [L2_W-1:0]    l2_idx_i,
  output logic [PA_W-1:0]    addr_o
);
  localparam int SH = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0] outer_addr;
  logic [PA_W-1:0] inner_addr;
  logic [PA_W-1:0] l1_scaled;
  logic [PA_W-1:0] l2_scaled;

  always_comb begin
    l1_scaled  = PA_W'(l1_idx_i) << SH;
    l2_scaled  = PA_W'(l2_idx_i) << SH;
    outer_addr = tbl_base_i + l1_scaled;
    inner_addr = {inner_frame_i, {OFF_W{1'b0}}} + l2_scaled;
    addr_o     = sel_inner_i ? inner_addr : outer_addr;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rsp_valid_i,
  input  logic        entry_present_i,
  output walk_state_e state_o,
  output logic        start_acc_o,
  output logic        rsp_take_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE:  if (start_i) state_d = WS_OUTER;
      WS_OUTER: if (rsp_valid_i) state_d = entry_present_i ? WS_INNER : WS_DONE;
      WS_INNER: if (rsp_valid_i) state_d = WS_DONE;
      WS_DONE:  state_d = WS_IDLE;
      default:  state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  assign state_o     = state_q;
  assign start_acc_o = (state_q == WS_IDLE) && start_i;
  assign rsp_take_o  = rsp_valid_i && ((state_q == WS_OUTER) || (state_q == WS_INNER));

  // R8: the done state lasts one cycle and returns to idle
  p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_DONE) |=> (state_q == WS_IDLE));

  // R9: once past the outer read, the walk cannot restart
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == WS_INNER) || (state_q == WS_DONE)) |=> (state_q != WS_OUTER));

  // R11: a response while idle does not move the walk
  p_idle_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == WS_IDLE) && !start_i) |=> (state_q == WS_IDLE));
endmodule

// File: rtl/pt_walk2.sv
module pt_walk2
  import ptw_pkg::*;
#(
  parameter int L1_W    = 8,
  parameter int L2_W    = 10,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32,
  localparam int VA_W        = L1_W + L2_W + OFF_W,
  localparam int FRAME_W     = PA_W - OFF_W,
  localparam int ENTRY_BYTES = ENTRY_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [PA_W-1:0]    ptbase_i,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_lvl_o,
  output logic [PA_W-1:0]    paddr_o
);
  logic               rst_sync_n;
  walk_state_e        state;
  logic               start_acc;
  logic               rsp_take;
  logic               rsp_present;
  logic [FRAME_W-1:0] rsp_frame;

  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    base_q;
  logic [FRAME_W-1:0] inner_frame_q;
  logic               inner_frame_en;

  logic [PA_W-1:0]    res_pa_q, res_pa_d;
  logic               res_fault_q, res_fault_d;
  logic               res_lvl_q, res_lvl_d;
  logic               res_en;
  logic               outer_end;
  logic               inner_end;

  logic [L1_W-1:0]    l1_idx;
  logic [L2_W-1:0]    l2_idx;
  logic [OFF_W-1:0]   offset;

  ptw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptw_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .start_i         (start_i),
    .rsp_valid_i     (mem_rsp_valid_i),
    .entry_present_i (rsp_present),
    .state_o         (state),
    .start_acc_o     (start_acc),
    .rsp_take_o      (rsp_take)
  );

  ptw_entry_decode #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W)) u_decode (
    .entry_i   (mem_rsp_data_i),
    .present_o (rsp_present),
    .frame_o   (rsp_frame)
  );

  assign l1_idx = vaddr_q[VA_W-1 -: L1_W];
  assign l2_idx = vaddr_q[OFF_W +: L2_W];
  assign offset = vaddr_q[OFF_W-1:0];

  ptw_addr_gen #(
    .PA_W(PA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_addr_gen (
    .sel_inner_i   (state == WS_INNER),
    .tbl_base_i    (base_q),
    .inner_frame_i (inner_frame_q),
    .l1_idx_i      (l1_idx),
    .l2_idx_i      (l2_idx),
    .addr_o        (mem_addr_o)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vaddr_q <= '0;
      base_q  <= '0;
    end else if (start_acc) begin
      vaddr_q <= vaddr_i;
      base_q  <= ptbase_i;
    end
  end

  // outer-level result
  assign inner_frame_en = rsp_take && (state == WS_OUTER) && rsp_present;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)         inner_frame_q <= '0;
    else if (inner_frame_en) inner_frame_q <= rsp_frame;
  end

  // walk results
  assign outer_end = rsp_take && (state == WS_OUTER) && !rsp_present;
  assign inner_end = rsp_take && (state == WS_INNER);
  assign res_en    = outer_end || inner_end;

  always_comb begin
    res_pa_d    = res_pa_q;
    res_fault_d = res_fault_q;
    res_lvl_d   = res_lvl_q;
    if (outer_end) begin
      res_pa_d    = '0;
      res_fault_d = 1'b1;
      res_lvl_d   = LVL_OUTER;
    end else if (inner_end) begin
      if (rsp_present) begin
        res_pa_d    = {rsp_frame, offset};
        res_fault_d = 1'b0;
        res_lvl_d   = LVL_OUTER;
      end else begin
        res_pa_d    = '0;
        res_fault_d = 1'b1;
        res_lvl_d   = LVL_INNER;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_pa_q    <= '0;
      res_fault_q <= 1'b0;
      res_lvl_q   <= 1'b0;
    end else if (res_en) begin
      res_pa_q    <= res_pa_d;
      res_fault_q <= res_fault_d;
      res_lvl_q   <= res_lvl_d;
    end
  end

  assign mem_req_o   = (state == WS_OUTER) || (state == WS_INNER);
  assign done_o      = (state == WS_DONE);
  assign paddr_o     = res_pa_q;
  assign fault_o     = res_fault_q;
  assign fault_lvl_o = res_lvl_q;

  // R7: a waiting read keeps its request and address
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R8: no read is outstanding while done is shown
  p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !mem_req_o);

  // R5 and R6: a faulted walk reports a zero physical address
  p_fault_zero_pa_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && fault_o) |-> (paddr_o == '0));

  // R10: results are frozen outside the done pulse
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> ($stable(paddr_o) && $stable(fault_o) && $stable(fault_lvl_o)));
endmodule

// File: tb/pt_walk2_tb.sv
module pt_walk2_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [29:0] vaddr_i;
  logic [31:0] ptbase_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        done_o;
  logic        fault_o;
  logic        fault_lvl_o;
  logic [31:0] paddr_o;

  pt_walk2 u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
    .ptbase_i(ptbase_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .done_o(done_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o), .paddr_o(paddr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] mem_model [logic [31:0]];
  int          lat   = 0;
  bit          spur  = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];
  bit          hold_viol = 0;
  int          wait_cnt = 0;
  bit          prev_wait = 0;
  logic [31:0] prev_addr = '0;

  logic [31:0] got_pa;
  logic        got_fault;
  logic        got_lvl;
  int          got_cyc;

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0070_0000;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk);
      if (prev_wait && (!mem_req_o || mem_addr_o != prev_addr)) hold_viol = 1;
      mem_rsp_valid_i = spur;
      mem_rsp_data_i  = spur ? 32'hFFFF_F001 : 32'h0;
      prev_wait = 0;
      if (mem_req_o) begin
        if (wait_cnt >= lat) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = rd_mem(mem_addr_o);
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr_o;
          rd_cnt++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
          prev_wait = 1;
          prev_addr = mem_addr_o;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic walk(input logic [29:0] va);
    rd_cnt = 0;
    hold_viol = 0;
    @(negedge clk);
    start_i = 1'b1;
    vaddr_i = va;
    @(negedge clk);
    start_i = 1'b0;
    got_cyc = 1;
    while (!done_o && got_cyc < 200) begin
      @(negedge clk);
      got_cyc++;
    end
    got_pa    = paddr_o;
    got_fault = fault_o;
    got_lvl   = fault_lvl_o;
  endtask

  // independent reference for a walk from base 'b'
  task automatic check_walk(input logic [29:0] va, input logic [31:0] b);
    logic [31:0] a1, a2, e1, e2, pa;
    logic        f, lv;
    int          nrd, cyc;
    a1 = b + {22'h0, va[29:22], 2'b00};
    e1 = rd_mem(a1);
    a2 = '0; pa = '0; f = 1'b0; lv = 1'b0; nrd = 1;
    if (!e1[0]) begin
      f = 1'b1; lv = 1'b0; cyc = 2 + lat;
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rd_mem(a2);
      nrd = 2; cyc = 3 + 2*lat;
      if (e2[0]) pa = {e2[31:12], va[11:0]};
      else begin f = 1'b1; lv = 1'b1; end
    end
    walk(va);
    chk(rd_addr[0] == a1, "R2", "outer read address", rd_addr[0], a1);
    chk(rd_cnt == nrd, f && !lv ? "R5" : "R3", "read count", rd_cnt, nrd);
    if (nrd == 2) chk(rd_addr[1] == a2, "R3", "inner read address", rd_addr[1], a2);
    if (!f)  chk(got_pa == pa && !got_fault, "R4", "physical address", got_pa, pa);
    else if (!lv) chk(got_fault && got_lvl == 1'b0 && got_pa == 0, "R5", "outer fault",
                      {got_fault, got_lvl, got_pa[29:0]}, 32'h8000_0000);
    else chk(got_fault && got_lvl == 1'b1 && got_pa == 0, "R6", "inner fault",
             {got_fault, got_lvl, got_pa[29:0]}, 32'hC000_0000);
    chk(got_cyc == cyc, "R8", "done latency", got_cyc, cyc);
    chk(!hold_viol, "R7", "request held while waiting", hold_viol, 0);
    @(negedge clk);
    chk(!done_o, "R8", "done is one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(!done_o && !mem_req_o && !fault_o && !fault_lvl_o,
        "R1", "control outputs after reset", {done_o, mem_req_o, fault_o, fault_lvl_o}, 0);
    chk(paddr_o == 0, "R1", "paddr after reset", paddr_o, 0);
  endtask

  task automatic t_basic();
    lat = 0;
    ptbase_i = BASE_A;
    check_walk({8'd3, 10'd5, 12'h123}, BASE_A);
    check_walk({8'd3, 10'd0, 12'h000}, BASE_A);
  endtask

  task automatic t_latency();
    lat = 3;
    ptbase_i = BASE_A;
    check_walk({8'd255, 10'd1023, 12'hFFF}, BASE_A);
    lat = 1;
    check_walk({8'd7, 10'd2, 12'h055}, BASE_A);
  endtask

  task automatic t_faults();
    lat = 0;
    ptbase_i = BASE_A;
    check_walk({8'd7, 10'd9, 12'h777}, BASE_A);
    check_walk({8'd3, 10'd6, 12'h456}, BASE_A);
    lat = 2;
    check_walk({8'd3, 10'd6, 12'h001}, BASE_A);
  endtask

  task automatic t_busy();
    logic [31:0] exp_pa;
    lat = 2;
    ptbase_i = BASE_A;
    exp_pa = 32'hABCD_E123;
    fork
      walk({8'd3, 10'd5, 12'h123});
      begin
        repeat (3) @(negedge clk);
        start_i  = 1'b1;
        vaddr_i  = {8'd255, 10'd1023, 12'hFFF};
        ptbase_i = BASE_B;
        @(negedge clk);
        start_i  = 1'b0;
      end
    join
    chk(got_pa == exp_pa && !got_fault, "R9", "result ignores mid-walk inputs", got_pa, exp_pa);
    chk(rd_addr[0] == BASE_A + 32'd12, "R9", "outer read used sampled base", rd_addr[0], BASE_A + 32'd12);
    repeat (3) @(negedge clk);
    chk(!mem_req_o && rd_cnt == 2, "R9", "no second walk launched", rd_cnt, 2);
    ptbase_i = BASE_A;
  endtask

  task automatic t_hold();
    logic [31:0] pa0;
    pa0 = paddr_o;
    ptbase_i = BASE_B;
    vaddr_i  = 30'h3FFF_FFFF;
    repeat (5) @(negedge clk);
    chk(paddr_o == pa0 && !done_o, "R10", "result held while idle", paddr_o, pa0);
    ptbase_i = BASE_A;
  endtask

  task automatic t_spurious();
    logic [31:0] pa0;
    logic        f0;
    pa0 = paddr_o;
    f0  = fault_o;
    spur = 1;
    repeat (4) begin
      @(negedge clk);
      chk(!done_o && !mem_req_o, "R11", "stray response no done/request", {done_o, mem_req_o}, 0);
    end
    spur = 0;
    @(negedge clk);
    chk(paddr_o == pa0 && fault_o == f0, "R11", "stray response leaves results", paddr_o, pa0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    vaddr_i = '0;
    ptbase_i = BASE_A;
    // outer table at BASE_A: entry 3 -> inner at 0x00200000, 255 -> 0x00300000
    mem_model[BASE_A + 32'd12]   = {20'h00200, 11'h0, 1'b1};
    mem_model[BASE_A + 32'd1020] = {20'h00300, 11'h0, 1'b1};
    mem_model[BASE_A + 32'd28]   = {20'h00400, 11'h0, 1'b0};
    mem_model[BASE_B + 32'd12]   = {20'h00500, 11'h0, 1'b1};
    // inner tables
    mem_model[32'h0020_0000 + 32'd20]   = {20'hABCDE, 11'h0, 1'b1};
    mem_model[32'h0020_0000 + 32'd0]    = {20'h00001, 11'h7FF, 1'b1};
    mem_model[32'h0020_0000 + 32'd24]   = {20'h55555, 11'h0, 1'b0};
    mem_model[32'h0030_0000 + 32'd4092] = {20'h12345, 11'h0, 1'b1};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_faults();
    t_busy();
    t_hold();
    t_spurious();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule